// File: doc/BRIEF.md
# Two-Tier Bus Arbiter

This block decides which of seven bus masters may drive a shared parallel bus: one internal bridge master (requester 0) and six external devices (requesters 1 to 6). Requests arrive as active-high levels. A single registered, one-hot grant vector comes out, so at most one master owns the bus. Each requester is placed in a high or a low priority tier. Inside a tier, ownership rotates round-robin, and the search starts just after the master that most recently began a transaction in that tier.

Two inputs describe bus activity. One level shows that the bus is idle. One pulse marks the cycle in which the granted owner starts its transaction. The grant may move while the bus is idle, or once the current owner has started. While a granted owner has not yet started on a busy bus, the grant stays where it is.

A small register port sets the tier of each master, bus parking toward the bridge, and a manual block for each external device. The same port turns on a 16-clock no-start timeout and automatic masking. An external device that holds the grant without starting sets its own timeout status bit. If automatic masking is on, that device is also removed from arbitration.

Top module: `pci_tier_arbiter`

## Requirements
- R1: After reset, `gnt_o` is all zero. Address 0 reads 0x01: the bridge is in the high tier, the external devices are in the low tier, and parking is off. Address 1 reads 0x00 and address 2 reads 0x00.
- R2: `gnt_o` is registered and one-hot or zero. With the bus idle, a single unmasked request on requester k yields `gnt_o` = 1<<k on the clock edge after the request is presented.
- R3: Address 0 bits 6:0 place requester k in the high tier when bit k is 1. Any active high-tier request wins over all low-tier requests.
- R4: Within a tier, the grant goes to the first requester after the last requester of that tier that pulsed `bus_start_i` while owning the grant, searching upward and wrapping.
- R5: The grant changes only in a cycle that follows a cycle with `bus_idle_i` high, or after the current owner has pulsed `bus_start_i`. Otherwise it is held, even if requests change.
- R6: With no effective request, the grant goes to the bridge (0x01) when address 0 bit 7 (park) is 1, and to nobody (0x00) when it is 0.
- R7: Address 1 bit j (j = 0..5) blocks the request of device j+1. A blocked device is never newly granted.
- R8: When address 1 bit 7 is 1, an external device that holds the grant for 16 consecutive cycles without starting sets address 2 bit j (device j+1). The bit is set on the 16th clock edge after the grant edge. With bit 7 at 0, no status bit is set.
- R9: Writing address 2 clears exactly the status bits written as 1. Other bits keep their value, and status bits change in no other way except by being set.
- R10: When address 1 bit 6 is 1, the timeout of R8 also masks the device's request. The grant leaves the device on the next clock edge while the bus is idle.
- R11: A write to address 1 with bit 6 at 0 removes every automatically set mask on that same write edge.
- R12: Address 3 reads 0x00. Registers read back through `reg_rdata_o` combinationally from `reg_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 7 | Request per master; bit 0 is the bridge, bits 1..6 external devices |
| bus_idle_i | input | 1 | High while no transaction is in progress |
| bus_start_i | input | 1 | Pulse: the granted owner starts its transaction this cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 mask, 2 timeout status, 3 spare) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| gnt_o | output | 7 | One-hot grant, same bit order as `req_i` |

## Verification
A change on `req_i`, `bus_idle_i` or `bus_start_i` shows up on `gnt_o` one clock edge later. A register write changes the read data after its own edge, and it moves the grant one edge after that. Timeout status appears on the 16th edge after the grant edge, and an automatic mask moves the grant on the 17th. The bench drives inputs just after a rising edge and places every expected value in a queue, tagged with the cycle count at which it is due. A monitor samples at the falling edge and compares only the entries due in that cycle. A result that comes one cycle early or late therefore fails.

// File: rtl/pta_pkg.sv
package pta_pkg;

    localparam int N_EXT  = 6;
    localparam int NREQ   = N_EXT + 1;
    localparam int IDX_W  = $clog2(NREQ);
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    typedef logic [NREQ-1:0]  req_vec_t;
    typedef logic [N_EXT-1:0] ext_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_MASK   = 2'd1,
        REG_TOSTAT = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    // control word: park enable above one tier bit per requester
    typedef struct packed {
        logic     park;
        req_vec_t high_tier;
    } ctrl_reg_t;

    // mask word: timeout enable, auto-mask enable, manual blocks
    typedef struct packed {
        logic     to_en;
        logic     am_en;
        ext_vec_t block;
    } mask_reg_t;

    localparam ctrl_reg_t CTRL_RST = '{park: 1'b0, high_tier: req_vec_t'(1)};

    function automatic logic [IDX_W-1:0] onehot_idx(req_vec_t v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < NREQ; i++)
            if (v[i]) r = IDX_W'(i);
        return r;
    endfunction

    // first set bit strictly after 'last', wrapping around
    function automatic req_vec_t rr_pick(req_vec_t v, logic [IDX_W-1:0] last);
        req_vec_t r;
        logic     found;
        int       k;
        r     = '0;
        found = 1'b0;
        for (int s = 1; s <= NREQ; s++) begin
            k = (int'(last) + s) % NREQ;
            if (!found && v[k]) begin
                r[k]  = 1'b1;
                found = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pta_tier_pick.sv
module pta_tier_pick
    import pta_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  req_vec_t         tier_req,
    input  logic             adv,
    input  logic [IDX_W-1:0] adv_idx,
    output req_vec_t         win,
    output logic             any
);

    logic [IDX_W-1:0] last_q;

    // the pointer moves only when an owner of this tier starts a transaction
    always_ff @(posedge clk) begin
        if (rst)
            last_q <= IDX_W'(NREQ - 1);
        else if (adv)
            last_q <= adv_idx;
    end

    always_comb begin
        win = rr_pick(tier_req, last_q);
        any = |tier_req;
    end

endmodule

// File: rtl/pta_timeout.sv
module pta_timeout
    import pta_pkg::*;
#(
    parameter int TO_CYCLES = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  ext_vec_t own_ext,
    input  logic     owner_started,
    input  logic     bus_start,
    input  logic     gnt_change,
    output ext_vec_t to_hit
);

    localparam int CNT_W = $clog2(TO_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             ext_owner;
    logic             waiting;
    logic             fire;

    assign ext_owner = |own_ext;
    assign waiting   = ext_owner && !owner_started && !bus_start && !gnt_change;
    assign fire      = waiting && (cnt_q == CNT_W'(TO_CYCLES - 1));
    assign to_hit    = fire ? own_ext : '0;

    always_ff @(posedge clk) begin
        if (rst || !waiting || fire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/pta_regs.sv
module pta_regs
    import pta_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  ext_vec_t          to_hit,
    output ctrl_reg_t         ctrl,
    output mask_reg_t         mask,
    output ext_vec_t          auto_mask,
    output ext_vec_t          to_status,
    output logic [REG_W-1:0]  rdata
);

    reg_sel_e  sel;
    mask_reg_t wr_mask;
    ext_vec_t  clr;
    logic      wr_ctrl;
    logic      wr_msk;

    assign sel     = reg_sel_e'(addr);
    assign wr_mask = mask_reg_t'(wdata);
    assign wr_ctrl = wr_en && (sel == REG_CTRL);
    assign wr_msk  = wr_en && (sel == REG_MASK);
    assign clr     = (wr_en && sel == REG_TOSTAT) ? wr_mask.block : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= CTRL_RST;
            mask      <= '0;
            auto_mask <= '0;
            to_status <= '0;
        end else begin
            if (wr_ctrl)
                ctrl <= ctrl_reg_t'(wdata);
            if (wr_msk)
                mask <= wr_mask;
            // set beats clear when both hit one bit in the same cycle
            to_status <= (to_status & ~clr) | (mask.to_en ? to_hit : '0);
            if (wr_msk && !wr_mask.am_en)
                auto_mask <= '0;
            else if (mask.am_en)
                auto_mask <= auto_mask | to_hit;
        end
    end

    always_comb begin
        unique case (sel)
            REG_CTRL:   rdata = ctrl;
            REG_MASK:   rdata = mask;
            REG_TOSTAT: rdata = REG_W'(to_status);
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/pci_tier_arbiter.sv
module pci_tier_arbiter
    import pta_pkg::*;
#(
    parameter int TO_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NREQ-1:0]   req_i,
    input  logic              bus_idle_i,
    input  logic              bus_start_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic [NREQ-1:0]   gnt_o
);

    localparam int N_TIER = 2;

    ctrl_reg_t        ctrl;
    mask_reg_t        mask;
    ext_vec_t         auto_mask;
    ext_vec_t         to_status;
    ext_vec_t         to_hit;
    req_vec_t         req_eff;
    req_vec_t         gnt_q;
    req_vec_t         gnt_d;
    req_vec_t         next_sel;
    logic             update_en;
    logic             gnt_change;
    logic             owner_started;
    logic             start_ev;
    logic [IDX_W-1:0] owner_idx;
    logic             owner_high;
    req_vec_t         tier_req [N_TIER];
    req_vec_t         tier_win [N_TIER];
    logic             tier_any [N_TIER];
    logic             tier_adv [N_TIER];

    pta_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_i),
        .addr      (reg_addr_i),
        .wdata     (reg_wdata_i),
        .to_hit    (to_hit),
        .ctrl      (ctrl),
        .mask      (mask),
        .auto_mask (auto_mask),
        .to_status (to_status),
        .rdata     (reg_rdata_o)
    );

    assign req_eff    = req_i & ~{(mask.block | auto_mask), 1'b0};
    assign owner_idx  = onehot_idx(gnt_q);
    assign owner_high = ctrl.high_tier[owner_idx];
    assign start_ev   = bus_start_i && (|gnt_q) && !owner_started;

    // tier 1 is the high tier, tier 0 the low tier
    for (genvar t = 0; t < N_TIER; t++) begin : g_tier
        localparam bit IS_HIGH = (t == 1);
        assign tier_req[t] = IS_HIGH ? (req_eff & ctrl.high_tier)
                                     : (req_eff & ~ctrl.high_tier);
        assign tier_adv[t] = start_ev && (owner_high == IS_HIGH);
        pta_tier_pick u_pick (
            .clk      (clk),
            .rst      (rst),
            .tier_req (tier_req[t]),
            .adv      (tier_adv[t]),
            .adv_idx  (owner_idx),
            .win      (tier_win[t]),
            .any      (tier_any[t])
        );
    end

    always_comb begin
        if (tier_any[1])
            next_sel = tier_win[1];
        else if (tier_any[0])
            next_sel = tier_win[0];
        else if (ctrl.park)
            next_sel = req_vec_t'(1);
        else
            next_sel = '0;
    end

    assign update_en  = bus_idle_i || owner_started;
    assign gnt_d      = update_en ? next_sel : gnt_q;
    assign gnt_change = (gnt_d != gnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q         <= '0;
            owner_started <= 1'b0;
        end else begin
            gnt_q <= gnt_d;
            if (gnt_change)
                owner_started <= 1'b0;
            else if (start_ev)
                owner_started <= 1'b1;
        end
    end

    pta_timeout #(.TO_CYCLES(TO_CYCLES)) u_timeout (
        .clk           (clk),
        .rst           (rst),
        .own_ext       (gnt_q[NREQ-1:1]),
        .owner_started (owner_started),
        .bus_start     (bus_start_i),
        .gnt_change    (gnt_change),
        .to_hit        (to_hit)
    );

    assign gnt_o = gnt_q;

endmodule

// File: rtl/pta_chk.sv
module pta_chk
    import pta_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NREQ-1:0]   req_i,
    input logic              bus_idle_i,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              wr_am_bit,
    input logic [NREQ-1:0]   gnt_o,
    input logic              owner_started,
    input logic              park,
    input logic              to_en,
    input ext_vec_t          block,
    input ext_vec_t          auto_mask,
    input ext_vec_t          to_status
);

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o)); // R2

    AST_GNT_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!bus_idle_i && !owner_started) |=> $stable(gnt_o)); // R5

    AST_PARK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (bus_idle_i && req_i == '0) |=> (gnt_o == ($past(park) ? req_vec_t'(1) : req_vec_t'(0)))); // R6

    AST_MASK_NO_NEW_GNT: assert property (@(posedge clk) disable iff (rst)
        ((gnt_o & ~$past(gnt_o) & $past({block, 1'b0})) == '0)); // R7

    AST_STATUS_GATED: assert property (@(posedge clk) disable iff (rst)
        !to_en |=> ((to_status & ~$past(to_status)) == '0)); // R8

    AST_STATUS_W1C_ONLY: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_i && reg_addr_i == 2'd2) |=> (($past(to_status) & ~to_status) == '0)); // R9

    AST_AUTO_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && reg_addr_i == 2'd1 && !wr_am_bit) |=> (auto_mask == '0)); // R11

endmodule

bind pci_tier_arbiter pta_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_i         (req_i),
    .bus_idle_i    (bus_idle_i),
    .reg_wr_i      (reg_wr_i),
    .reg_addr_i    (reg_addr_i),
    .wr_am_bit     (reg_wdata_i[6]),
    .gnt_o         (gnt_o),
    .owner_started (owner_started),
    .park          (ctrl.park),
    .to_en         (mask.to_en),
    .block         (mask.block),
    .auto_mask     (auto_mask),
    .to_status     (to_status)
);

// File: tb/pci_tier_arbiter_tb_top.sv
module pci_tier_arbiter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int F_GNT      = 0;
    localparam int F_RD       = 1;

    typedef struct {
        int         due;
        int         fld;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] req_i = '0;
    logic       bus_idle_i = 1'b1;
    logic       bus_start_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [1:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic [6:0] gnt_o;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb_q[$];
    item_t it;
    logic [7:0] act;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pci_tier_arbiter dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_i),
        .bus_idle_i  (bus_idle_i),
        .bus_start_i (bus_start_i),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .gnt_o       (gnt_o)
    );

    // monitor: compares every entry due in this cycle at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            it  = sb_q.pop_front();
            act = (it.fld == F_RD) ? reg_rdata_o : {1'b0, gnt_o};
            checks++;
            if (act !== it.exp || it.due != cyc) begin
                errors++;
                $display("FAIL %s: cycle %0d actual 0x%02h expected 0x%02h",
                         it.tag, cyc, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_at(int off, int fld, logic [7:0] exp, string tag);
        item_t e;
        e.due = cyc + off;
        e.fld = fld;
        e.exp = exp;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_wr_i    = 1'b1;
        reg_addr_i  = a;
        reg_wdata_i = d;
        tick();
        reg_wr_i    = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: all requirements, actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;

        // R1 reset state
        reg_addr_i = 2'd0;
        expect_at(0, F_RD, 8'h01, "R1 ctrl reset");
        expect_at(0, F_GNT, 8'h00, "R1 gnt reset");
        tick();
        reg_addr_i = 2'd1;
        expect_at(0, F_RD, 8'h00, "R1 mask reset");
        tick();
        reg_addr_i = 2'd2;
        expect_at(0, F_RD, 8'h00, "R1 status reset");
        tick();

        // R2 single request, R4 rotation, R5 hold rules
        req_i = 7'h06;
        expect_at(1, F_GNT, 8'h02, "R2 single low-tier grant");
        tick();
        bus_start_i = 1'b1;
        bus_idle_i  = 1'b0;
        tick();
        bus_start_i = 1'b0;
        expect_at(0, F_GNT, 8'h02, "R5 owner kept on start cycle");
        expect_at(1, F_GNT, 8'h04, "R4 rotate after started winner");
        tick();
        req_i = 7'h02;
        expect_at(1, F_GNT, 8'h04, "R5 hold while busy and not started");
        tick();
        bus_idle_i = 1'b1;
        expect_at(1, F_GNT, 8'h02, "R5 move once idle");
        tick();

        // R8 no status while timeout disabled
        repeat (20) tick();
        reg_addr_i = 2'd2;
        expect_at(0, F_RD, 8'h00, "R8 no status with timeout off");
        tick();

        // R3 tiers
        req_i = 7'h09;
        expect_at(1, F_GNT, 8'h01, "R3 bridge high tier wins");
        tick();
        wr(2'd0, 8'h08);
        expect_at(0, F_RD, 8'h08, "R3 ctrl readback");
        expect_at(1, F_GNT, 8'h08, "R3 device 3 promoted wins");
        tick();

        // R6 parking
        req_i = 7'h00;
        expect_at(1, F_GNT, 8'h00, "R6 no park no grant");
        tick();
        wr(2'd0, 8'h81);
        expect_at(1, F_GNT, 8'h01, "R6 park to bridge");
        tick();

        // R7 manual mask, R12 spare address
        req_i = 7'h04;
        expect_at(1, F_GNT, 8'h04, "R7 device 2 before mask");
        tick();
        wr(2'd1, 8'h02);
        expect_at(0, F_RD, 8'h02, "R7 mask readback");
        expect_at(1, F_GNT, 8'h01, "R7 masked device loses grant");
        tick();
        reg_addr_i = 2'd3;
        expect_at(0, F_RD, 8'h00, "R12 spare reads zero");
        tick();

        // R8 timeout, R9 write-one-to-clear
        wr(2'd1, 8'h80);
        req_i      = 7'h10;
        reg_addr_i = 2'd2;
        expect_at(1, F_GNT, 8'h10, "R8 device 4 granted");
        expect_at(16, F_RD, 8'h00, "R8 no status before 16 cycles");
        expect_at(17, F_RD, 8'h08, "R8 status on 16th edge");
        repeat (17) tick();
        wr(2'd2, 8'h04);
        expect_at(0, F_RD, 8'h08, "R9 other bit write keeps status");
        req_i = 7'h20;
        expect_at(1, F_GNT, 8'h20, "R8 device 5 granted");
        expect_at(16, F_RD, 8'h08, "R9 status held while second waits");
        expect_at(17, F_RD, 8'h18, "R9 second bit independent");
        repeat (17) tick();
        wr(2'd2, 8'h08);
        expect_at(0, F_RD, 8'h10, "R9 only written bit cleared");
        tick();

        // R10 auto-mask, R11 release
        req_i = 7'h00;
        expect_at(1, F_GNT, 8'h01, "R6 park with no requests");
        tick();
        wr(2'd1, 8'hC0);
        expect_at(0, F_RD, 8'hC0, "R10 mask enables readback");
        req_i      = 7'h40;
        expect_at(1, F_GNT, 8'h40, "R10 device 6 granted");
        tick();
        reg_addr_i = 2'd2;
        expect_at(15, F_RD, 8'h10, "R10 status before expiry");
        expect_at(16, F_RD, 8'h30, "R10 status at expiry");
        expect_at(16, F_GNT, 8'h40, "R10 grant held at expiry edge");
        expect_at(17, F_GNT, 8'h01, "R10 auto-masked device dropped");
        repeat (17) tick();
        wr(2'd1, 8'h80);
        expect_at(0, F_RD, 8'h80, "R11 enable cleared readback");
        expect_at(1, F_GNT, 8'h40, "R11 auto mask released");
        tick();

        repeat (4) tick();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule